// File: doc/BRIEF.md
# DMA Read Prefetch FIFO Engine

This block copies a contiguous range of memory into an internal byte buffer. A controller hands it a start address and a length in bytes. The engine then splits the range into read requests and sends them on a request/response memory interface. Several requests may be in flight at once. New requests go out whenever the buffer has unreserved room and a tracking slot is free, so the buffer is kept as full as it can be. Each request reserves its buffer space when it is issued. Responses may come back in any order, but their data is written into the buffer strictly in the order the requests were issued.

A consumer takes bytes out through a read port. Each read asks for 1 to RD_MAX bytes and either succeeds in full or fails with nothing removed, so the consumer handles underrun itself. The controller also has three further means of control. A flush empties the stored bytes. A stop abandons the current block and discards its outstanding data. A new block may be chained as soon as the last request of the current one has been sent. Single-cycle pulses report when the last request of a block has gone out and when the engine has drained completely.

Top module: `dma_prefetch_fifo`

## Requirements
- R1: After reset, fill_level is 0, active is 0, at_eob is 1, mreq_valid is 0 and no event pulse is high.
- R2: Requests of a block carry consecutive addresses starting at the block address. Each length is between 1 and MAX_REQ and does not exceed the bytes left in the block. The lengths sum to the block length, and no more than MAX_OUT requests are outstanding at once.
- R3: Space is reserved for each request when it is issued, so fill_level never exceeds FIFO_BYTES, even with every slot in flight.
- R4: Whatever the order in which responses return, the consumer receives the block's bytes in ascending address order. Response byte i (bits 8i+7:8i) is the byte at request address + i, and mrsp_tag echoes the request's mreq_tag.
- R5: A read with rd_len not above fill_level pulses rd_ok in the next cycle. rd_data then carries the oldest byte in bits 7:0 and the following bytes upward, with bytes beyond rd_len zero, and those bytes are removed.
- R6: A read with rd_len above fill_level pulses rd_fail in the next cycle and removes nothing: the next successful read returns the same bytes.
- R7: eob_pulse is high for exactly one cycle per block, in the cycle after that block's last request is issued, and at_eob is high from then on.
- R8: A start given while at_eob is high is accepted even with responses outstanding. The new block's bytes follow the old block's bytes in the buffer.
- R9: A start given while at_eob is low is ignored and pulses start_err in the next cycle. The current block continues unchanged.
- R10: A stop blocks request issue in its own cycle, forces at_eob high, and discards the data of every request not yet written back. No eob_pulse follows for the stopped block.
- R11: idle_pulse is high for one cycle, in the first cycle in which active is low after being high. This happens once the last outstanding response has been written back, including after a stop.
- R12: A start accepted in the cycle in which active would otherwise fall suppresses that idle_pulse. Only one idle_pulse is seen, at the end of the chained block.
- R13: A flush makes fill_level 0 in the next cycle and leaves outstanding requests in place. Their data is still written back afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (one-cycle pulse) |
| start_addr | input | AW | First byte address of the block |
| start_len | input | LW | Block length in bytes |
| stop | input | 1 | Abandon the current block |
| flush | input | 1 | Empty the stored bytes |
| mreq_valid | output | 1 | Read request issued this cycle (always accepted) |
| mreq_addr | output | AW | Request byte address |
| mreq_len | output | $clog2(MAX_REQ+1) | Request length in bytes |
| mreq_tag | output | $clog2(MAX_OUT) | Slot identifier of the request |
| mrsp_valid | input | 1 | Response data present |
| mrsp_tag | input | $clog2(MAX_OUT) | Tag of the request being answered |
| mrsp_data | input | 8*MAX_REQ | Response bytes, byte 0 in the low bits |
| rd_req | input | 1 | Consumer read request |
| rd_len | input | $clog2(RD_MAX+1) | Bytes requested |
| rd_ok | output | 1 | Previous read succeeded |
| rd_fail | output | 1 | Previous read failed (underrun) |
| rd_data | output | 8*RD_MAX | Bytes of a successful read |
| fill_level | output | $clog2(FIFO_BYTES+1) | Bytes stored |
| active | output | 1 | Requests outstanding or block not fully requested |
| at_eob | output | 1 | Last request of the block has been issued |
| eob_pulse | output | 1 | End-of-block event |
| idle_pulse | output | 1 | Engine became idle |
| start_err | output | 1 | A start was rejected |

## Verification
The hardest case to reach is a start that arrives in exactly the cycle in which the last outstanding response is being written back. Free-running responders almost never line up with that cycle. The bench therefore takes the memory side into manual mode. It releases the single pending response in a chosen cycle and raises start in the following cycle, which is the write-back cycle. It holds responses back in the same way to build states with every slot in flight. From those states it stops, flushes or chains blocks. Sweeps over block alignment, length, read size and in-order versus reversed response order then cover request splitting and the ordering of writeback.

// File: rtl/dma_prefetch_fifo.sv
module dma_prefetch_fifo #(
  parameter int AW         = 16,
  parameter int LW         = 12,
  parameter int FIFO_BYTES = 16,
  parameter int MAX_REQ    = 4,
  parameter int MAX_OUT    = 4,
  parameter int RD_MAX     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [AW-1:0]                start_addr,
  input  logic [LW-1:0]                start_len,
  input  logic                         stop,
  input  logic                         flush,
  output logic                         mreq_valid,
  output logic [AW-1:0]                mreq_addr,
  output logic [$clog2(MAX_REQ+1)-1:0] mreq_len,
  output logic [$clog2(MAX_OUT)-1:0]   mreq_tag,
  input  logic                         mrsp_valid,
  input  logic [$clog2(MAX_OUT)-1:0]   mrsp_tag,
  input  logic [8*MAX_REQ-1:0]         mrsp_data,
  input  logic                         rd_req,
  input  logic [$clog2(RD_MAX+1)-1:0]  rd_len,
  output logic                         rd_ok,
  output logic                         rd_fail,
  output logic [8*RD_MAX-1:0]          rd_data,
  output logic [$clog2(FIFO_BYTES+1)-1:0] fill_level,
  output logic                         active,
  output logic                         at_eob,
  output logic                         eob_pulse,
  output logic                         idle_pulse,
  output logic                         start_err
);
  localparam int FPW = $clog2(FIFO_BYTES);
  localparam int CW  = $clog2(FIFO_BYTES+1);
  localparam int SW  = $clog2(MAX_OUT);
  localparam int OW  = $clog2(MAX_OUT+1);
  localparam int QW  = $clog2(MAX_REQ+1);
  localparam int RW  = $clog2(RD_MAX+1);

  logic [AW-1:0] next_addr, end_addr, remaining, cap_w, free_w, req_len_w;
  logic [CW-1:0] count, inflight, free;
  logic [FPW-1:0] wptr, rptr;
  logic [7:0] mem [FIFO_BYTES];
  logic [QW-1:0] sl_len [MAX_OUT];
  logic [8*MAX_REQ-1:0] sl_data [MAX_OUT];
  logic [MAX_OUT-1:0] sl_done, sl_kill;
  logic [SW-1:0] head, tail;
  logic [OW-1:0] occ, occ_n;
  logic [QW-1:0] req_len, wlen;
  logic [RW-1:0] rlen;
  logic issue, retire, keep, rd_go, start_acc;
  logic at_eob_i, at_eob_n, active_i, active_n;
  logic eob_q, idle_q, err_q, rok_q, rfail_q;
  logic [8*RD_MAX-1:0] rbytes, rdata_q;

  assign remaining = end_addr - next_addr;
  assign at_eob_i  = (remaining == '0);
  assign free      = CW'(FIFO_BYTES) - count - inflight;
  assign cap_w     = (remaining < AW'(MAX_REQ)) ? remaining : AW'(MAX_REQ);
  assign free_w    = AW'(free);
  assign req_len_w = (cap_w < free_w) ? cap_w : free_w;
  assign req_len   = QW'(req_len_w);

  assign issue     = !stop && !at_eob_i && (occ != OW'(MAX_OUT)) && (free != '0);
  assign retire    = (occ != '0) && sl_done[head];
  assign keep      = retire && !sl_kill[head] && !stop;
  assign wlen      = keep ? sl_len[head] : '0;
  assign rd_go     = rd_req && (int'(rd_len) <= int'(count));
  assign rlen      = rd_go ? rd_len : '0;
  assign start_acc = start && at_eob_i;
  assign occ_n     = occ + OW'(issue) - OW'(retire);

  always_comb begin
    if (start_acc)  at_eob_n = (start_len == '0);
    else if (stop)  at_eob_n = 1'b1;
    else if (issue) at_eob_n = (req_len_w == remaining);
    else            at_eob_n = at_eob_i;
  end

  assign active_i = (occ != '0) || !at_eob_i;
  assign active_n = (occ_n != '0) || !at_eob_n;

  assign mreq_valid = issue;
  assign mreq_addr  = next_addr;
  assign mreq_len   = req_len;
  assign mreq_tag   = tail;
  assign fill_level = count;
  assign active     = active_i;
  assign at_eob     = at_eob_i;
  assign eob_pulse  = eob_q;
  assign idle_pulse = idle_q;
  assign start_err  = err_q;
  assign rd_ok      = rok_q;
  assign rd_fail    = rfail_q;
  assign rd_data    = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      wptr <= wptr + FPW'(wlen);
      if (flush) begin
        count <= '0;
        rptr  <= wptr + FPW'(wlen);
      end else begin
        count <= count + CW'(wlen) - CW'(rlen);
        rptr  <= rptr + FPW'(rlen);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_REQ; i++)
      if (i < int'(wlen)) mem[wptr + FPW'(i)] <= sl_data[head][8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < RD_MAX; i++)
      rbytes[8*i +: 8] = (i < int'(rd_len)) ? mem[rptr + FPW'(i)] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rok_q   <= 1'b0;
      rfail_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      rok_q   <= rd_go;
      rfail_q <= rd_req && !rd_go;
      rdata_q <= rd_go ? rbytes : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      inflight  <= '0;
      next_addr <= '0;
      end_addr  <= '0;
      sl_done   <= '0;
      sl_kill   <= '0;
      eob_q     <= 1'b0;
      idle_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      head     <= head + SW'(retire);
      tail     <= tail + SW'(issue);
      occ      <= occ_n;
      inflight <= inflight + (issue ? CW'(req_len) : '0) - (retire ? CW'(sl_len[head]) : '0);
      if (stop) sl_kill <= '1;
      if (mrsp_valid) sl_done[mrsp_tag] <= 1'b1;
      if (retire) sl_done[head] <= 1'b0;
      if (issue) begin
        sl_done[tail] <= 1'b0;
        sl_kill[tail] <= 1'b0;
      end
      if (start_acc) next_addr <= start_addr;
      else if (issue) next_addr <= next_addr + req_len_w;
      if (start_acc) end_addr <= start_addr + AW'(start_len);
      else if (stop) end_addr <= next_addr;
      eob_q  <= issue && (req_len_w == remaining);
      idle_q <= active_i && !active_n && !start_acc;
      err_q  <= start && !at_eob_i;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) sl_len[tail] <= req_len;
    if (mrsp_valid) sl_data[mrsp_tag] <= mrsp_data;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(inflight)) <= FIFO_BYTES);

  // R2
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_len != '0) && (int'(mreq_len) <= MAX_REQ));

  // R7
  eob_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob_pulse |-> $past(mreq_valid) && at_eob);

  // R6
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail |-> $past(rd_req) && (int'($past(rd_len)) > int'($past(fill_level))));

  // R9
  start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> $past(active) && !$past(at_eob));

  // R10
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> at_eob && !eob_pulse);

  // R12
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> !$past(start && at_eob));

  // R5
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok || rd_fail) |-> $past(rd_req) && !(rd_ok && rd_fail));
endmodule

// File: tb/tb_dma_prefetch_fifo.sv
`timescale 1ns/1ps
module tb_dma_prefetch_fifo;
  localparam int AW = 16, LW = 12, FB = 16, MR = 4, MO = 4, RM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, flush = 0, rd_req = 0, mrsp_valid = 0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic mreq_valid, rd_ok, rd_fail, active, at_eob, eob_pulse, idle_pulse, start_err;
  logic [AW-1:0] mreq_addr;
  logic [2:0] mreq_len, rd_len = '0;
  logic [1:0] mreq_tag, mrsp_tag = '0;
  logic [8*MR-1:0] mrsp_data = '0;
  logic [8*RM-1:0] rd_data;
  logic [4:0] fill_level;

  dma_prefetch_fifo #(.AW(AW), .LW(LW), .FIFO_BYTES(FB), .MAX_REQ(MR), .MAX_OUT(MO), .RD_MAX(RM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .start_len(start_len),
    .stop(stop), .flush(flush), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
    .mreq_len(mreq_len), .mreq_tag(mreq_tag), .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag),
    .mrsp_data(mrsp_data), .rd_req(rd_req), .rd_len(rd_len), .rd_ok(rd_ok), .rd_fail(rd_fail),
    .rd_data(rd_data), .fill_level(fill_level), .active(active), .at_eob(at_eob),
    .eob_pulse(eob_pulse), .idle_pulse(idle_pulse), .start_err(start_err));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int eob_cnt = 0, idle_cnt = 0, err_cnt = 0, max_level = 0;
  int pa [8], pl [8], pt [8];
  int np = 0, quiet = 0, mode = 0;
  bit manual = 0, man_go = 0, no_req = 0, exp_eob = 0;
  int man_idx = 0, req_next = 0, req_left = 0;

  function automatic logic [7:0] mb(input int a);
    logic [15:0] x;
    x = 16'(a);
    return 8'(x * 16'd13) ^ x[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_rsp(input int idx);
    mrsp_valid = 1'b1;
    mrsp_tag = 2'(pt[idx]);
    for (int b = 0; b < MR; b++) mrsp_data[8*b +: 8] = mb(pa[idx] + b);
    for (int j = idx; j < np - 1; j++) begin
      pa[j] = pa[j+1]; pl[j] = pl[j+1]; pt[j] = pt[j+1];
    end
    np--;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (exp_eob) begin
        chk(eob_pulse === 1'b1, "R7", "eob cycle after last request", int'(eob_pulse), 1);
        exp_eob = 0;
      end
      if (eob_pulse) eob_cnt++;
      if (idle_pulse) idle_cnt++;
      if (start_err) err_cnt++;
      if (int'(fill_level) > max_level) max_level = int'(fill_level);
      mrsp_valid = 1'b0;
      if (!manual && np > 0 && (np >= 2 || quiet >= 2)) drive_rsp(mode == 1 ? np - 1 : 0);
      else if (manual && man_go) begin
        drive_rsp(man_idx);
        man_go = 0;
      end
      if (mreq_valid) begin
        quiet = 0;
        chk(!no_req, "R10", "request after stop", 1, 0);
        chk(int'(mreq_addr) == (req_next & 16'hFFFF), "R2", "request address", int'(mreq_addr), req_next & 16'hFFFF);
        chk(mreq_len >= 1 && int'(mreq_len) <= MR && int'(mreq_len) <= req_left, "R2", "request length", int'(mreq_len), req_left);
        chk(np < MO, "R2", "outstanding bound", np + 1, MO);
        pa[np] = int'(mreq_addr); pl[np] = int'(mreq_len); pt[np] = int'(mreq_tag);
        np++;
        req_next += int'(mreq_len);
        req_left -= int'(mreq_len);
        if (req_left == 0) exp_eob = 1;
      end else quiet++;
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic start_blk(input int a, input int l, input bit track);
    start = 1; start_addr = AW'(a); start_len = LW'(l);
    if (track) begin req_next = a; req_left = l; end
    tick;
    start = 0;
  endtask

  task automatic man_resp(input int idx);
    man_idx = idx; man_go = 1;
    tick;
  endtask

  task automatic drain(input int a, input int l, input int k);
    int e = a, left = l, kk = 0, guard = 0;
    bit pend = 0, pok = 0;
    while ((left > 0 || pend) && guard < 4000) begin
      guard++;
      if (pend) begin
        if (pok) begin
          logic [8*RM-1:0] ev = '0;
          for (int b = 0; b < kk; b++) ev[8*b +: 8] = mb(e + b);
          chk(rd_ok === 1'b1 && rd_fail === 1'b0, "R5", "read accepted", int'(rd_ok), 1);
          chk(rd_data === ev, "R4", "read bytes in address order", int'(rd_data), int'(ev));
          e += kk; left -= kk;
        end else
          chk(rd_fail === 1'b1 && rd_ok === 1'b0, "R6", "underrun reported", int'(rd_fail), 1);
        pend = 0;
      end
      rd_req = 0;
      if (left > 0) begin
        kk = (k < left) ? k : left;
        pok = (int'(fill_level) >= kk);
        rd_req = 1; rd_len = 3'(kk); pend = 1;
      end
      tick;
    end
    rd_req = 0;
    chk(left == 0, "R4", "block fully delivered", left, 0);
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 60 && active; i++) tick;
    tick; tick;
  endtask

  task automatic run_blk(input int a, input int l, input int k, input int m);
    int e0 = eob_cnt, i0 = idle_cnt;
    mode = m;
    start_blk(a, l, 1);
    drain(a, l, k);
    wait_idle;
    chk(eob_cnt - e0 == 1, "R7", "one eob per block", eob_cnt - e0, 1);
    chk(idle_cnt - i0 == 1, "R11", "one idle per block", idle_cnt - i0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int e0, i0, r0;
    int lens [7] = '{1, 3, 4, 5, 16, 17, 37};
    repeat (3) tick;
    rst_n = 1;
    tick;
    // R1
    chk(fill_level == 0, "R1", "level after reset", int'(fill_level), 0);
    chk(active == 0 && at_eob == 1, "R1", "idle state after reset", int'(active), 0);
    chk(mreq_valid == 0 && eob_pulse == 0 && idle_pulse == 0 && start_err == 0, "R1", "quiet outputs", int'(mreq_valid), 0);

    // R2 R4 R5 R6 R7 R11 sweep
    for (int ai = 0; ai < 2; ai++)
      for (int li = 0; li < 7; li++)
        for (int k = 1; k <= RM; k++)
          for (int m = 0; m < 2; m++)
            run_blk(ai ? 16'hFFFD : 16'h0100 + li * 64, lens[li], k, m);

    // R9: start while requests of the block remain
    manual = 1; e0 = eob_cnt; i0 = idle_cnt; r0 = err_cnt;
    start_blk(16'h0200, 40, 1);
    repeat (6) tick;
    chk(active == 1 && at_eob == 0, "R9", "block in progress", int'(at_eob), 0);
    chk(fill_level == 0 && np == MO, "R3", "all slots held, space reserved", np, MO);
    start_blk(16'h0900, 8, 0);
    chk(start_err === 1'b1, "R9", "start_err pulse", int'(start_err), 1);
    manual = 0; mode = 0;
    drain(16'h0200, 40, 4);
    wait_idle;
    chk(err_cnt - r0 == 1, "R9", "single error", err_cnt - r0, 1);
    chk(eob_cnt - e0 == 1, "R9", "old block completed", eob_cnt - e0, 1);

    // R8: chained block with responses outstanding, answered in reverse
    manual = 1; e0 = eob_cnt; i0 = idle_cnt; r0 = err_cnt;
    start_blk(16'h0300, 6, 1);
    repeat (4) tick;
    chk(at_eob == 1 && active == 1, "R8", "at eob with outstanding", int'(at_eob), 1);
    start_blk(16'h0340, 5, 1);
    chk(start_err === 1'b0, "R8", "chained start accepted", int'(start_err), 0);
    repeat (4) tick;
    while (np > 0) man_resp(np - 1);
    manual = 0;
    drain(16'h0300, 6, 4);
    drain(16'h0340, 5, 3);
    wait_idle;
    chk(eob_cnt - e0 == 2, "R8", "two eob events", eob_cnt - e0, 2);
    chk(idle_cnt - i0 == 1, "R8", "idle only at the end", idle_cnt - i0, 1);

    // R12: start in the write-back cycle of the last response
    manual = 1; e0 = eob_cnt; i0 = idle_cnt;
    start_blk(16'h0400, 3, 1);
    repeat (3) tick;
    man_resp(0);
    start_blk(16'h0480, 2, 1);
    manual = 0;
    drain(16'h0400, 3, 2);
    drain(16'h0480, 2, 2);
    wait_idle;
    chk(idle_cnt - i0 == 1, "R12", "idle suppressed by chained start", idle_cnt - i0, 1);

    // R10 R11: stop with every slot outstanding
    manual = 1; e0 = eob_cnt; i0 = idle_cnt;
    start_blk(16'h0500, 40, 1);
    repeat (6) tick;
    stop = 1; no_req = 1;
    tick;
    stop = 0;
    chk(at_eob == 1 && active == 1, "R10", "at eob after stop", int'(at_eob), 1);
    man_resp(1);
    while (np > 0) man_resp(0);
    repeat (3) tick;
    chk(fill_level == 0, "R10", "stopped data discarded", int'(fill_level), 0);
    chk(active == 0, "R11", "inactive after stop drain", int'(active), 0);
    chk(idle_cnt - i0 == 1, "R11", "idle after stop", idle_cnt - i0, 1);
    chk(eob_cnt - e0 == 0, "R10", "no eob after stop", eob_cnt - e0, 0);
    no_req = 0; manual = 0;
    run_blk(16'h0600, 9, 2, 1);

    // R13: flush with a request still outstanding
    manual = 1;
    start_blk(16'h0700, 12, 1);
    repeat (5) tick;
    man_resp(0);
    man_resp(0);
    repeat (2) tick;
    chk(fill_level == 8, "R13", "level before flush", int'(fill_level), 8);
    flush = 1;
    tick;
    flush = 0;
    chk(fill_level == 0, "R13", "level after flush", int'(fill_level), 0);
    man_resp(0);
    repeat (2) tick;
    chk(fill_level == 4, "R13", "in-flight data lands after flush", int'(fill_level), 4);
    manual = 0;
    drain(16'h0708, 4, 4);
    wait_idle;

    chk(max_level <= FB, "R3", "peak level bounded", max_level, FB);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule